// File: doc/BRIEF.md
# Peripheral Clock Gating Register

This block holds one bus-visible register with one bit per peripheral. A set bit stops the clock of that peripheral and blocks access to its I/O registers. A clear bit lets the peripheral run. The block drives one clock enable per peripheral. That enable stands in for a real clock-gate cell, so a peripheral whose enable is low does not advance. Its state stays where it was, and it carries on from that same state once the enable comes back. Nothing is reset when the peripheral restarts.

The power controller supplies a sleep-mode code. The per-bit gating is used only in the active and idle modes. Every other mode stops all peripheral clocks, whatever the register holds. In those modes the register keeps its contents and can still be read and written. Each clock enable is captured on the falling edge of the core clock, so it changes only while the clock is low. A register write therefore shows up on the enable at the falling edge that follows the write's rising edge.

The block also drives one access enable per peripheral. It is high exactly when that peripheral is clocked. The peripheral's bus decode uses it to drop writes and return zero on reads while the peripheral is gated.

Top module: `pcg_top`

## Requirements
- R1: After reset the gating register reads 0x00. In active mode (sleep code 0), every clock enable and every access enable is high.
- R2: A write with `bus_wr` high and `bus_addr` equal to `REG_ADDR` (default 0x0) loads `bus_wdata` into the register. While `bus_rd` is high and `bus_addr` equals `REG_ADDR`, `bus_rdata` returns the register. At any other time `bus_rdata` is zero.
- R3: In active or idle mode, `periph_clk_en[i]` is the inverse of register bit i. The new value appears at the falling clock edge that follows the rising edge on which the write is taken, which is within one core clock cycle.
- R4: `periph_acc_en[i]` is high exactly when `periph_clk_en[i]` is high, as seen at every rising clock edge.
- R5: Sleep code 0 (active) and sleep code 1 (idle) apply the per-bit gating. Any other code (2 to 7) drives every clock enable low. In those modes the register keeps its value and still accepts writes, and the new value takes effect when the mode returns to 0 or 1.
- R6: A peripheral clocked by `periph_clk_en[i]` does not advance while bit i is set. After the bit is cleared it continues from the value it held when it stopped, with no reset.
- R7: A write whose `bus_addr` differs from `REG_ADDR` leaves the register and all enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rd | input | 1 | Read strobe |
| sleep_mode | input | MODE_W (3) | Sleep-mode code from the power controller |
| periph_clk_en | output | NUM_PERIPH (8) | Per-peripheral clock enable, changes on the falling edge |
| periph_acc_en | output | NUM_PERIPH (8) | Per-peripheral register-access enable |
| bus_rdata | output | DATA_W (8) | Read data |

## Verification
The hardest behaviour to show from the ports is freeze and resume. The block itself does not know what a peripheral holds. The bench therefore clocks a small counter from one enable and gates that enable for several steps. It checks that the counter stays at the value it had when stopped, and that after the bit is cleared it counts on from exactly that value. The bench also writes the register while a deep sleep code holds all enables low. It then returns to active mode, to show that the value written earlier takes effect only then.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   localparam int unsigned PCG_MODE_W = 3;

   typedef enum logic [PCG_MODE_W-1:0] {
      PCG_MODE_RUN  = 3'd0,
      PCG_MODE_IDLE = 3'd1
   } pcg_mode_e;
endpackage

// File: rtl/pcg_regfile.sv
module pcg_regfile #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  rd,
   output logic [NUM_PERIPH-1:0] gate_q,
   output logic [DATA_W-1:0]     rdata
);
   localparam int unsigned PAD_W = DATA_W - NUM_PERIPH;

   if (NUM_PERIPH == 0 || NUM_PERIPH > DATA_W) begin : g_bad_width
      $error("pcg_regfile: NUM_PERIPH must be 1..DATA_W");
   end

   logic wr_hit;
   logic rd_hit;
   logic [DATA_W-1:0] rd_word;

   assign wr_hit = wr && (addr == REG_ADDR);
   assign rd_hit = rd && (addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
      end else if (wr_hit) begin
         gate_q <= wdata[NUM_PERIPH-1:0];
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign rd_word = {{PAD_W{1'b0}}, gate_q};
   end else begin : g_nopad
      assign rd_word = gate_q;
   end

   assign rdata = rd_hit ? rd_word : '0;

   assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (gate_q == $past(wdata[NUM_PERIPH-1:0])));

   assert_hold_unless_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(gate_q));
endmodule

// File: rtl/pcg_mode_filter.sv
module pcg_mode_filter #(
   parameter int unsigned MODE_W = pcg_pkg::PCG_MODE_W
) (
   input  logic [MODE_W-1:0] mode,
   output logic              run_ok
);
   import pcg_pkg::*;

   if (MODE_W != PCG_MODE_W) begin : g_bad_mode_w
      $error("pcg_mode_filter: MODE_W must match the package mode width");
   end

   always_comb begin
      unique case (mode)
         PCG_MODE_RUN,
         PCG_MODE_IDLE: run_ok = 1'b1;
         default:       run_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/pcg_enable_stage.sv
module pcg_enable_stage #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter bit          NEG_EDGE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PERIPH-1:0] gate_q,
   input  logic                  run_ok,
   output logic [NUM_PERIPH-1:0] clk_en
);
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
      logic want;
      assign want = run_ok && !gate_q[i];

      if (NEG_EDGE) begin : g_neg
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) clk_en[i] <= 1'b0;
            else        clk_en[i] <= want;
         end

         assert_gated_bit_off_R3: assert property (@(negedge clk) disable iff (!rst_n)
            gate_q[i] |=> !clk_en[i]);

         assert_open_bit_on_R3: assert property (@(negedge clk) disable iff (!rst_n)
            (run_ok && !gate_q[i]) |=> clk_en[i]);
      end else begin : g_pos
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clk_en[i] <= 1'b0;
            else        clk_en[i] <= want;
         end
      end
   end

   if (NEG_EDGE) begin : g_sleep_chk
      assert_deep_sleep_stops_R5: assert property (@(negedge clk) disable iff (!rst_n)
         !run_ok |=> (clk_en == '0));
   end
endmodule

// File: rtl/pcg_top.sv
module pcg_top #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned MODE_W     = pcg_pkg::PCG_MODE_W,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0,
   parameter bit          NEG_EDGE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   input  logic [MODE_W-1:0]     sleep_mode,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic [NUM_PERIPH-1:0] periph_acc_en,
   output logic [DATA_W-1:0]     bus_rdata
);
   logic [NUM_PERIPH-1:0] gate_q;
   logic                  run_ok;

   pcg_regfile #(
      .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
   ) i_regfile (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .rd(bus_rd), .gate_q(gate_q), .rdata(bus_rdata)
   );

   pcg_mode_filter #(.MODE_W(MODE_W)) i_mode (
      .mode(sleep_mode), .run_ok(run_ok)
   );

   pcg_enable_stage #(.NUM_PERIPH(NUM_PERIPH), .NEG_EDGE(NEG_EDGE)) i_stage (
      .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .run_ok(run_ok), .clk_en(periph_clk_en)
   );

   assign periph_acc_en = {NUM_PERIPH{run_ok}} & ~gate_q;

   if (NEG_EDGE) begin : g_acc_chk
      assert_acc_tracks_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
         periph_acc_en == periph_clk_en);
   end

   assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_pcg_top.sv
module test_pcg_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] REG = 4'h0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [2:0] sleep_mode = '0;
   logic [7:0] periph_clk_en;
   logic [7:0] periph_acc_en;
   logic [7:0] bus_rdata;

   int checks = 0;
   int fails = 0;

   typedef struct {
      logic [7:0] en;
      logic [7:0] rd;
      string      req;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] model_reg = '0;
   logic [15:0] cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcg_top i_pcg_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .sleep_mode(sleep_mode),
      .periph_clk_en(periph_clk_en), .periph_acc_en(periph_acc_en), .bus_rdata(bus_rdata)
   );

   // peripheral model clocked by enable bit 2
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (periph_clk_en[2]) cnt <= cnt + 16'd1;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [7:0] d, input logic [2:0] m, input string req);
      exp_t e;
      @(posedge clk); #2;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; sleep_mode = m;
      @(posedge clk); #2;
      bus_wr = 1'b0;
      #4;
      if (wr && a == REG) model_reg = d;
      e.en  = (m == 3'd0 || m == 3'd1) ? ~model_reg : 8'h00;
      e.rd  = (rd && a == REG) ? model_reg : 8'h00;
      e.req = req;
      sb.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk); #3;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            check({e.req, " clk_en"}, {8'h0, periph_clk_en}, {8'h0, e.en});
            check({e.req, " acc_en (R4)"}, {8'h0, periph_acc_en}, {8'h0, e.en});
            check({e.req, " rdata"}, {8'h0, bus_rdata}, {8'h0, e.rd});
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : driver
      logic [15:0] frozen;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step(0, 1, REG, 8'h00, 3'd0, "R1 reset");
      step(1, 1, REG, 8'hA5, 3'd0, "R2 R3 write A5");
      step(0, 1, REG, 8'h00, 3'd1, "R5 idle");
      step(1, 1, 4'h3, 8'h3C, 3'd0, "R7 foreign addr");
      step(0, 1, REG, 8'h00, 3'd2, "R5 deep code 2");
      step(1, 1, REG, 8'h0F, 3'd5, "R5 write in deep");
      step(0, 0, REG, 8'h00, 3'd7, "R5 deep code 7");
      step(0, 1, REG, 8'h00, 3'd0, "R5 back to active");
      step(1, 0, REG, 8'h00, 3'd0, "R3 clear all");
      step(1, 1, REG, 8'hFF, 3'd1, "R3 gate all idle");
      step(1, 1, REG, 8'h80, 3'd0, "R3 top bit");
      step(1, 1, REG, 8'h00, 3'd0, "R3 release");
      // R6 freeze and resume
      step(1, 0, REG, 8'h04, 3'd0, "R6 gate bit 2");
      frozen = cnt;
      for (int k = 0; k < 4; k++) step(0, 1, REG, 8'h00, 3'd0, "R6 gated");
      check("R6 frozen while gated", cnt, frozen);
      step(1, 0, REG, 8'h00, 3'd0, "R6 ungate");
      check("R6 no advance before enable", cnt, frozen);
      step(0, 0, REG, 8'h00, 3'd0, "R6 running");
      check("R6 resumes from held value", cnt, frozen + 16'd2);
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule